// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block produces the time-multiplexed drive pattern for a passive segment LCD with up to four common lines and forty segment lines. For every pin it puts out a 2-bit voltage-level code, which an analog level generator turns into a real voltage, and an output enable that lets the pin float. It steps through the commons once per frame. Each common gets two slots: a positive slot, then an inverted one, so the drive has no DC component. The block never decides contrast or generates voltages. It only decides which level each pin should see and when the buffers may drive.

The display image is a flat vector of 160 bits, seen as twenty 8-bit registers. This vector, the duty select, the bias select and the 3-bit drive-time code are all level-held control inputs with no handshake. The block copies them at the start of each frame, so whatever a writer does in the middle of a frame never shows up in that frame. Software may change them at any time. A one-cycle `tick` from an external prescaler advances the sequence. The parameter `TICK_CYC` states how many clocks apart those ticks are. Nothing is produced while the supply-ready input is low. There is no streaming interface, so no back-pressure rule applies.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `supply_ok` is low, every enable and every level code is 0 from the next clock edge on, and ticks are ignored. The first tick seen with `supply_ok` high starts a frame at common 0, positive slot.
- R2: Commons in use number `duty_sel`+1 (0: static, 1: two, 2: three, 3: four). Each tick moves positive to inverted on the same common, or from inverted on to the positive slot of the next common. A tick on the inverted slot of the last common in use starts a new frame.
- R3: Level codes: 00 ground, 01 one-third (half for 1/2 bias), 10 two-thirds, 11 full. The addressed common is at 11 in the positive slot and at 00 in the inverted slot.
- R4: A common in use but not addressed is at 01 (positive) or 10 (inverted) with `bias_third`=1, and at 01 in both slots with `bias_third`=0. A common not in use stays at 00 and is never enabled.
- R5: An energized segment is driven opposite the addressed common at full amplitude: 00 in the positive slot, 11 in the inverted slot.
- R6: A segment that is not energized is in phase with the addressed common. With one common it is 11 (positive) or 00 (inverted). Otherwise it is 10/01 with `bias_third`=1, and 01 in both slots with `bias_third`=0.
- R7: Common k takes segment j from register 5k + j/8, bit j mod 8. Register r is `disp_data[8r+7:8r]`, and a set bit means energized.
- R8: The display vector, duty, bias and drive code are sampled only on the tick that starts a frame. A change between frame starts alters no output until the next frame.
- R9: After each tick taken with `supply_ok` high, all enables of pins in use are high for W = (code+1)·`DRV_UNIT` clock cycles, starting with the cycle after that tick's edge. They are then low until the next tick. If W reaches the tick spacing, the enables stay high.
- R10: With more than one common in use, W is clamped to `TICK_CYC`/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle prescaled LCD clock strobe |
| supply_ok | input | 1 | LCD supply at target; low inhibits all outputs |
| duty_sel | input | 2 | Commons in use minus one |
| bias_third | input | 1 | 1: 1/3 bias, 0: 1/2 bias |
| drive_code | input | 3 | Drive-window length code |
| disp_data | input | 160 | Display image, twenty 8-bit registers |
| com_lvl | output | 8 | Level code per common, common k at bits 2k+1:2k |
| com_oe | output | 4 | Drive enable per common |
| seg_lvl | output | 80 | Level code per segment, segment j at bits 2j+1:2j |
| seg_oe | output | 40 | Drive enable per segment |

## Verification
Two things can happen on the same edge. The tick that ends a frame also copies the new image and configuration, and it reloads the drive window. That reload has to use the drive code and duty being copied on that edge, not the old ones. The bench changes the duty, bias, code and image at random in the middle of frames. The next frame start therefore often brings a new duty and a new code together, for example moving between static and multi-common drive, where the clamp switches on or off. It then counts the enable cycles of the first slot of the new frame and compares them with the window the new settings call for. In the same slot it checks that the levels follow the image copied on that edge.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'b00;
  localparam lvl_t LVL_LO   = 2'b01;
  localparam lvl_t LVL_HI   = 2'b10;
  localparam lvl_t LVL_FULL = 2'b11;

  // level of one common line in the current slot
  function automatic lvl_t com_level(input logic addressed, input logic inverted,
                                     input logic third_bias);
    if (addressed)       return inverted ? LVL_GND : LVL_FULL;
    else if (third_bias) return inverted ? LVL_HI  : LVL_LO;
    else                 return LVL_LO;
  endfunction

  // level of one segment line in the current slot
  function automatic lvl_t seg_level(input logic energized, input logic inverted,
                                     input logic third_bias, input logic single_com);
    if (energized)       return inverted ? LVL_FULL : LVL_GND;
    else if (single_com) return inverted ? LVL_GND  : LVL_FULL;
    else if (third_bias) return inverted ? LVL_LO   : LVL_HI;
    else                 return LVL_LO;
  endfunction
endpackage

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
  parameter int SLOT_W = 2,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              supply_ok,
  input  logic [SLOT_W-1:0] duty_sel,
  input  logic              bias_third,
  input  logic [CODE_W-1:0] drive_code,
  output logic              frame_start,
  output logic              running,
  output logic [SLOT_W-1:0] slot,
  output logic              inverted,
  output logic [SLOT_W-1:0] duty_q,
  output logic              bias_q,
  output logic [CODE_W-1:0] code_q
);
  logic at_end;

  assign at_end      = inverted && (slot == duty_q);
  assign frame_start = tick && supply_ok && (!running || at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      slot     <= '0;
      inverted <= 1'b0;
      duty_q   <= '0;
      bias_q   <= 1'b0;
      code_q   <= '0;
    end else if (!supply_ok) begin
      running  <= 1'b0;
      slot     <= '0;
      inverted <= 1'b0;
    end else if (frame_start) begin
      running  <= 1'b1;
      slot     <= '0;
      inverted <= 1'b0;
      duty_q   <= duty_sel;
      bias_q   <= bias_third;
      code_q   <= drive_code;
    end else if (tick && running) begin
      if (inverted) begin
        slot     <= slot + 1'b1;
        inverted <= 1'b0;
      end else begin
        inverted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_shadow.sv
module lcd_shadow #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int SLOT_W  = 2,
  localparam int DISP_W = NUM_COM * NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [DISP_W-1:0]  disp_data,
  input  logic [SLOT_W-1:0]  slot,
  output logic [NUM_SEG-1:0] row
);
  logic [DISP_W-1:0]  image_q;
  logic [NUM_SEG-1:0] rows [NUM_COM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       image_q <= '0;
    else if (capture) image_q <= disp_data;
  end

  for (genvar k = 0; k < NUM_COM; k++) begin : g_row
    assign rows[k] = image_q[k*NUM_SEG +: NUM_SEG];
  end

  assign row = rows[slot];
endmodule

// File: rtl/lcd_drive_window.sv
module lcd_drive_window #(
  parameter int TICK_CYC = 16,
  parameter int DRV_UNIT = 2,
  parameter int CODE_W   = 3,
  localparam int MAX_WIN = (2 ** CODE_W) * DRV_UNIT,
  localparam int HALF    = TICK_CYC / 2,
  localparam int CNT_W   = $clog2(MAX_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              multi,
  output logic              active
);
  logic [CNT_W-1:0] left_q;
  int full_len;
  int use_len;

  always_comb begin
    full_len = (int'(code) + 1) * DRV_UNIT;
    use_len  = (multi && full_len > HALF) ? HALF : full_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (!supply_ok)      left_q <= '0;
    else if (load)            left_q <= CNT_W'(use_len);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/lcd_pin_levels.sv
module lcd_pin_levels
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int SLOT_W  = 2
) (
  input  logic                 running,
  input  logic                 win_on,
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 inverted,
  input  logic [SLOT_W-1:0]    duty_q,
  input  logic                 bias_q,
  input  logic [NUM_SEG-1:0]   seg_row,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [NUM_COM-1:0]   com_oe,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_SEG-1:0]   seg_oe
);
  logic single_com;
  assign single_com = (duty_q == '0);

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    localparam logic [SLOT_W-1:0] KIDX = SLOT_W'(k);
    logic in_use;
    assign in_use = (KIDX <= duty_q);
    assign com_lvl[2*k +: 2] = (running && in_use) ?
                               com_level(slot == KIDX, inverted, bias_q) : LVL_GND;
    assign com_oe[k] = running && win_on && in_use;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign seg_lvl[2*j +: 2] = running ?
                               seg_level(seg_row[j], inverted, bias_q, single_com) : LVL_GND;
    assign seg_oe[j] = running && win_on;
  end
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 40,
  parameter int REG_W    = 8,
  parameter int CODE_W   = 3,
  parameter int TICK_CYC = 16,
  parameter int DRV_UNIT = 2,
  localparam int SLOT_W  = $clog2(NUM_COM),
  localparam int NUM_REG = NUM_COM * NUM_SEG / REG_W,
  localparam int DISP_W  = NUM_REG * REG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 supply_ok,
  input  logic [SLOT_W-1:0]    duty_sel,
  input  logic                 bias_third,
  input  logic [CODE_W-1:0]    drive_code,
  input  logic [DISP_W-1:0]    disp_data,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [NUM_COM-1:0]   com_oe,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_SEG-1:0]   seg_oe
);
  logic              frame_start;
  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic              inv_q;
  logic [SLOT_W-1:0] duty_q;
  logic              bias_q;
  logic [CODE_W-1:0] code_q;
  logic [NUM_SEG-1:0] seg_row;
  logic              win_on;
  logic [CODE_W-1:0] code_eff;
  logic              multi_eff;

  lcd_frame_seq #(.SLOT_W(SLOT_W), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .duty_sel(duty_sel), .bias_third(bias_third), .drive_code(drive_code),
    .frame_start(frame_start), .running(run_q), .slot(slot_q), .inverted(inv_q),
    .duty_q(duty_q), .bias_q(bias_q), .code_q(code_q)
  );

  lcd_shadow #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .SLOT_W(SLOT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .capture(frame_start), .disp_data(disp_data),
    .slot(slot_q), .row(seg_row)
  );

  // the frame-start tick reloads the window with the settings being captured
  assign code_eff  = frame_start ? drive_code : code_q;
  assign multi_eff = frame_start ? (duty_sel != '0) : (duty_q != '0);

  lcd_drive_window #(.TICK_CYC(TICK_CYC), .DRV_UNIT(DRV_UNIT), .CODE_W(CODE_W)) u_win (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .load(tick && supply_ok),
    .code(code_eff), .multi(multi_eff), .active(win_on)
  );

  lcd_pin_levels #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .SLOT_W(SLOT_W)) u_pins (
    .running(run_q), .win_on(win_on), .slot(slot_q), .inverted(inv_q),
    .duty_q(duty_q), .bias_q(bias_q), .seg_row(seg_row),
    .com_lvl(com_lvl), .com_oe(com_oe), .seg_lvl(seg_lvl), .seg_oe(seg_oe)
  );
endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 40,
  parameter int TICK_CYC = 16,
  localparam int SLOT_W  = $clog2(NUM_COM)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 supply_ok,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [NUM_COM-1:0]   com_oe,
  input logic [NUM_SEG-1:0]   seg_oe,
  input logic                 run_q,
  input logic                 inv_q,
  input logic [SLOT_W-1:0]    slot_q,
  input logic [SLOT_W-1:0]    duty_q
);
  int extreme_cnt;
  logic [NUM_COM-1:0] in_use_mask;
  logic [15:0] since_tick;

  always_comb begin
    extreme_cnt = 0;
    for (int k = 0; k < NUM_COM; k++)
      if (com_oe[k] && (com_lvl[2*k +: 2] == 2'b00 || com_lvl[2*k +: 2] == 2'b11))
        extreme_cnt++;
    for (int k = 0; k < NUM_COM; k++)
      in_use_mask[k] = (k <= int'(duty_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_tick <= '0;
    else if (tick && supply_ok)   since_tick <= 16'd1;
    else if (since_tick != '1)    since_tick <= since_tick + 16'd1;
  end

  assert_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (com_oe == '0 && seg_oe == '0 && com_lvl == '0));

  assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && supply_ok && run_q && !(inv_q && slot_q == duty_q)) |=> (inv_q != $past(inv_q)));

  assert_one_full_common_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|com_oe) |-> (extreme_cnt == 1));

  assert_unused_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (com_oe & ~in_use_mask) == '0);

  assert_enable_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seg_oe[0]) |-> $past(tick && supply_ok));

  assert_window_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_oe[0] && duty_q != '0) |-> (since_tick <= 16'(TICK_CYC / 2)));
endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(
  .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .TICK_CYC(TICK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
  .com_lvl(com_lvl), .com_oe(com_oe), .seg_oe(seg_oe),
  .run_q(run_q), .inv_q(inv_q), .slot_q(slot_q), .duty_q(duty_q)
);

// File: tb/lcd_mux_driver_test.sv
module lcd_mux_driver_test;
  localparam int NCOM = 4, NSEG = 40, TCYC = 16, UNIT = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, supply_ok = 1'b0;
  logic [1:0]   duty_sel = '0;
  logic         bias_third = 1'b0;
  logic [2:0]   drive_code = '0;
  logic [159:0] disp_data = '0;
  logic [7:0]   com_lvl;
  logic [3:0]   com_oe;
  logic [79:0]  seg_lvl;
  logic [39:0]  seg_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_run = 0, m_inv = 0, m_bias = 0;
  int m_slot = 0, m_n = 1, m_code = 0;
  logic [159:0] m_img = '0;

  lcd_mux_driver uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .duty_sel(duty_sel), .bias_third(bias_third), .drive_code(drive_code),
    .disp_data(disp_data), .com_lvl(com_lvl), .com_oe(com_oe),
    .seg_lvl(seg_lvl), .seg_oe(seg_oe)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what, input logic [79:0] got,
                       input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_com();
    logic [7:0] v = '0;
    for (int k = 0; k < NCOM; k++) begin
      logic [1:0] l;
      if (!m_run || k >= m_n) l = 2'd0;
      else if (k == m_slot)   l = m_inv ? 2'd0 : 2'd3;
      else if (m_bias)        l = m_inv ? 2'd2 : 2'd1;
      else                    l = 2'd1;
      v[2*k +: 2] = l;
    end
    return v;
  endfunction

  function automatic logic [79:0] exp_seg();
    logic [79:0] v = '0;
    for (int j = 0; j < NSEG; j++) begin
      logic [1:0] l;
      bit on = m_img[(m_slot*5 + j/8)*8 + (j%8)];
      if (!m_run)        l = 2'd0;
      else if (on)       l = m_inv ? 2'd3 : 2'd0;
      else if (m_n == 1) l = m_inv ? 2'd0 : 2'd3;
      else if (m_bias)   l = m_inv ? 2'd1 : 2'd2;
      else               l = 2'd1;
      v[2*j +: 2] = l;
    end
    return v;
  endfunction

  function automatic int exp_win();
    int w = (m_code + 1) * UNIT;
    if (!m_run) return 0;
    if (m_n > 1 && w > TCYC/2) w = TCYC/2;
    if (w > TCYC) w = TCYC;
    return w;
  endfunction

  task automatic randomize_inputs();
    disp_data  = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    duty_sel   = 2'($urandom_range(0, 3));
    bias_third = 1'($urandom_range(0, 1));
    drive_code = 3'($urandom_range(0, 7));
  endtask

  // one tick period; called at a negedge, returns at the negedge before the next tick
  task automatic step(input bit perturb);
    int on_cnt = 0, bad = 0;
    logic [7:0]  ec;
    logic [79:0] es;
    logic [3:0]  mask;
    if (supply_ok) begin
      if (!m_run || (m_inv && m_slot == m_n - 1)) begin
        m_run = 1; m_slot = 0; m_inv = 0;
        m_img = disp_data; m_n = int'(duty_sel) + 1;
        m_bias = bias_third; m_code = int'(drive_code);
      end else if (m_inv) begin
        m_slot++; m_inv = 0;
      end else m_inv = 1;
    end else m_run = 0;
    ec = exp_com(); es = exp_seg();
    mask = m_run ? 4'((1 << m_n) - 1) : 4'd0;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(com_lvl == ec, "R2 R3 R4 common levels", 80'(com_lvl), 80'(ec));
    check(seg_lvl == es, "R5 R6 R7 segment levels", seg_lvl, es);
    for (int i = 0; i < TCYC; i++) begin
      if (i > 0) @(negedge clk);
      if (seg_oe == '1 && com_oe == mask && mask != 0) on_cnt++;
      else if (!(seg_oe == '0 && com_oe == '0)) bad++;
      if (i == 5 && perturb) randomize_inputs();
    end
    check(com_lvl == ec && seg_lvl == es, "R8 levels held through slot",
          80'(com_lvl) ^ seg_lvl, 80'(ec) ^ es);
    check(on_cnt == exp_win() && bad == 0, "R9 R10 drive window cycles",
          80'(on_cnt + 1000*bad), 80'(exp_win()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(com_lvl == '0 && seg_lvl == '0 && com_oe == '0 && seg_oe == '0,
          "R1 reset state", 80'(com_oe), 80'(0));
    // ticks ignored while supply not ready
    disp_data = {5{32'hA5C3_0F96}};
    step(0);
    step(0);
    supply_ok = 1'b1;
    // directed: every duty and bias pairing, two frames each
    for (int d = 0; d < 4; d++) begin
      for (int b = 0; b < 2; b++) begin
        duty_sel = 2'(d); bias_third = 1'(b); drive_code = 3'((d*3 + b*5) % 8);
        disp_data = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        for (int s = 0; s < 4*(d+1) + 2; s++) step(0);
      end
    end
    // directed mapping: only register 7 bit 3 set, energizes COM1 segment 19 (R7)
    disp_data = '0; disp_data[7*8 + 3] = 1'b1;
    duty_sel = 2'd3; bias_third = 1'b1; drive_code = 3'd7;
    for (int s = 0; s < 18; s++) step(0);
    // static duty with the longest window: enables continuous (R9)
    duty_sel = 2'd0; drive_code = 3'd7;
    for (int s = 0; s < 6; s++) step(0);
    // supply drop mid-frame then restart at COM0 (R1)
    duty_sel = 2'd2; drive_code = 3'd1;
    for (int s = 0; s < 9; s++) step(0);
    supply_ok = 1'b0;
    m_run = 0;
    @(negedge clk);
    check(com_oe == '0 && seg_oe == '0 && com_lvl == '0 && seg_lvl == '0,
          "R1 inhibit after supply drop", 80'(com_lvl), 80'(0));
    step(0);
    supply_ok = 1'b1;
    for (int s = 0; s < 8; s++) step(0);
    // random phase with mid-frame changes and occasional supply drops
    for (int s = 0; s < 320; s++) begin
      if ($urandom_range(0, 39) == 0) begin
        supply_ok = 1'b0; m_run = 0;
        step(0);
        supply_ok = 1'b1;
      end
      step($urandom_range(0, 2) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule